// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Front End

This block sits in front of a small single-port memory and behaves, cycle for cycle, like a pipelined synchronous SRAM with a common data bus. On every rising clock edge it samples an address, write data, three chip selects, two address strobes, a burst step input, a global write, a byte-write enable and per-lane byte selects. From these it works out whether the edge starts an access, continues or holds a burst, writes, reads or deselects the part.

Read data leaves through an output register, one edge after the address was taken. The drive enable for the shared bus goes through a two-stage enable pipeline. Because of this pipeline the outputs stay on for one more cycle after a deselect, and they stay off during the first cycle of a read that follows a deselect. The burst order is not computed here. The block exports the two low base address bits and a step index, and a neighbouring generator returns the low address bits for the current beat.

The bus is split into `wdata` in, `rdata` out and a drive enable `rdata_oe`. The external output-enable pin gates `rdata_oe` without a register. The interface has a fixed latency and no back-pressure: every edge is one access slot.

Top module: `sync_sram_fe`

## Requirements
- R1: An edge with an accepted strobe starts an access only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination deselects the part: it writes nothing and does not drive the bus afterwards.
- R2: When both strobes are low, the processor strobe `cpu_stb_n` wins. While `cs_a_n`=1 the processor strobe is ignored entirely, and an ongoing burst simply continues.
- R3: An access started by `cpu_stb_n` is a read whatever the write inputs are. A write to that address takes effect on the following edge, as a burst-continue cycle with write inputs active.
- R4: An access started by `ctl_stb_n` (with the processor strobe not accepted) writes memory on that same edge when the write inputs request it. Otherwise it is a read.
- R5: With `wr_all_n`=0, all lanes are written. Otherwise lane i (bits 8i+7..8i) is written only when `wr_byte_n`=0 and `lane_n[i]`=0. Any lane combination is allowed, and lanes that are not written keep their contents.
- R6: The read data for an address sampled at edge T appears on `rdata`, with `rdata_oe` high (output enable low), after edge T+1.
- R7: After a read starts from the deselected state, `rdata_oe` stays low in the cycle that follows the starting edge.
- R8: When a deselect is sampled at edge T right after a read at edge T-1, the bus is still driven after edge T and is released after edge T+1.
- R9: `rdata_oe` is low whenever the current inputs form a write cycle, regardless of `out_en_n`. After a write it stays low until a strobe starts a new read.
- R10: `out_en_n`=1 forces `rdata_oe` low in the same cycle, with no clock edge needed.
- R11: During a burst, `step_n`=0 advances `seq_idx` by one (modulo 4), and `step_n`=1 holds it. The beat address is the base address with its low two bits replaced by `seq_lsb`. A new start resets the index to 0.
- R12: A synchronous low `rst_n` leaves the part deselected, with `rdata_oe` low and `seq_idx` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Address taken at an accepted strobe |
| wdata | input | DATA_W | Write data for a write cycle |
| cs_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| cs_b | input | 1 | Chip select B, active high |
| cs_c_n | input | 1 | Chip select C, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | DATA_W/8 | Per-lane byte selects, active low |
| out_en_n | input | 1 | Output enable, active low, unregistered |
| seq_lsb | input | 2 | Low address bits for the current beat, from the burst generator |
| seq_base | output | 2 | Low two bits of the latched base address |
| seq_idx | output | 2 | Beat index for the current cycle |
| rdata | output | DATA_W | Registered read data |
| rdata_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that every input is stable around the rising edge, and that `seq_lsb` is a settled combinational function of `seq_base` and `seq_idx` before each edge. They also assume that `DATA_W` is a multiple of eight and that `ADDR_W` exceeds two. The bench drives all inputs two nanoseconds after each rising edge and models the burst generator as a continuous interleaved function (`seq_base ^ seq_idx`), so the generator input always settles before it is sampled. Memory is read only at addresses that were written earlier in the run, so no check depends on contents the block never wrote.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
  localparam int SEQ_W  = 2;
  localparam int LANE_W = 8;

  // kind of work a clock edge performs
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_DESEL = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/sram_fe_decode.sv
module sram_fe_decode
  import sram_fe_pkg::*;
#(
  parameter int NLANE = 4
) (
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [NLANE-1:0] lane_n,
  input  logic             busy,
  input  logic             wr_hold,
  output logic             start,
  output acc_kind_e        kind,
  output logic [NLANE-1:0] lane_we
);
  logic             cpu_go;
  logic             ctl_go;
  logic             chip_on;
  logic [NLANE-1:0] lane_req;

  always_comb begin
    // processor strobe counts only with select A active, and wins over the other
    cpu_go   = !cpu_stb_n && !cs_a_n;
    ctl_go   = !cpu_go && !ctl_stb_n;
    start    = cpu_go || ctl_go;
    chip_on  = !cs_a_n && cs_b && !cs_c_n;
    lane_req = !wr_all_n ? {NLANE{1'b1}} : (wr_byte_n ? {NLANE{1'b0}} : ~lane_n);

    kind = ACC_NONE;
    if (start) begin
      if (!chip_on)                kind = ACC_DESEL;
      else if (ctl_go && |lane_req) kind = ACC_WRITE;
      else                         kind = ACC_READ;
    end else if (busy) begin
      if (|lane_req)      kind = ACC_WRITE;
      else if (!wr_hold)  kind = ACC_READ;
    end

    lane_we = (kind == ACC_WRITE) ? lane_req : {NLANE{1'b0}};
  end
endmodule

// File: rtl/sram_fe_track.sv
module sram_fe_track
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  acc_kind_e         kind,
  input  logic              step_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEQ_W-1:0]  seq_lsb,
  output logic              busy,
  output logic              wr_hold,
  output logic [SEQ_W-1:0]  seq_base,
  output logic [SEQ_W-1:0]  seq_idx,
  output logic [ADDR_W-1:0] eff_addr
);
  logic              busy_q;
  logic              hold_q;
  logic [SEQ_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              stepping;

  assign stepping = busy_q && !start && !step_n;
  assign seq_idx  = stepping ? cnt_q + SEQ_W'(1) : cnt_q;
  assign seq_base = base_q[SEQ_W-1:0];
  assign eff_addr = start ? addr : {base_q[ADDR_W-1:SEQ_W], seq_lsb};
  assign busy     = busy_q;
  assign wr_hold  = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      if (start) begin
        busy_q <= (kind != ACC_DESEL);
        base_q <= addr;
        cnt_q  <= '0;
        hold_q <= (kind == ACC_WRITE);
      end else begin
        if (stepping) cnt_q <= cnt_q + SEQ_W'(1);
        if (kind == ACC_WRITE) hold_q <= 1'b1;
      end
    end
  end

  assert_desel_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && kind == ACC_DESEL) |=> !busy_q);

  assert_step_adv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && busy_q && !step_n) |=> (cnt_q == $past(cnt_q) + SEQ_W'(1)));

  assert_start_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0));
endmodule

// File: rtl/sram_fe_array.sv
module sram_fe_array
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic [DATA_W/LANE_W-1:0] lane_we,
  input  logic [ADDR_W-1:0]        eff_addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     rd_take,
  input  logic                     ld,
  output logic [DATA_W-1:0]        rdata
);
  localparam int NLANE = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] raddr_q;

  always_ff @(posedge clk) begin
    if (rd_take) raddr_q <= eff_addr;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] mem_l [DEPTH];
    logic [LANE_W-1:0] out_b;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem_l[eff_addr] <= wdata[g*LANE_W +: LANE_W];
      if (ld)         out_b <= mem_l[raddr_q];
    end

    assign rdata[g*LANE_W +: LANE_W] = out_b;
  end
endmodule

// File: rtl/sram_fe_outpipe.sv
module sram_fe_outpipe (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_take,
  input  logic wr_now,
  input  logic out_en_n,
  output logic rd_vld,
  output logic rdata_oe
);
  logic rd_vld_q;
  logic out_vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      rd_vld_q  <= rd_take;
      out_vld_q <= rd_vld_q && !wr_now;
    end
  end

  assign rd_vld   = rd_vld_q;
  assign rdata_oe = out_vld_q && !out_en_n && !wr_now;

  assert_read_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take ##1 !wr_now |=> out_vld_q);

  assert_first_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld_q |=> !out_vld_q);

  assert_wr_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> !out_vld_q);
endmodule

// File: rtl/sync_sram_fe.sv
module sync_sram_fe
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     cs_a_n,
  input  logic                     cs_b,
  input  logic                     cs_c_n,
  input  logic                     cpu_stb_n,
  input  logic                     ctl_stb_n,
  input  logic                     step_n,
  input  logic                     wr_all_n,
  input  logic                     wr_byte_n,
  input  logic [DATA_W/8-1:0]      lane_n,
  input  logic                     out_en_n,
  input  logic [1:0]               seq_lsb,
  output logic [1:0]               seq_base,
  output logic [1:0]               seq_idx,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_oe
);
  localparam int NLANE = DATA_W / LANE_W;

  logic              start;
  acc_kind_e         kind;
  logic [NLANE-1:0]  lane_we;
  logic              busy;
  logic              wr_hold;
  logic [ADDR_W-1:0] eff_addr;
  logic              rd_vld;
  logic              rd_take;
  logic              wr_now;

  assign rd_take = (kind == ACC_READ);
  assign wr_now  = (kind == ACC_WRITE);

  sram_fe_decode #(.NLANE(NLANE)) u_decode (
    .cs_a_n    (cs_a_n),
    .cs_b      (cs_b),
    .cs_c_n    (cs_c_n),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_n    (lane_n),
    .busy      (busy),
    .wr_hold   (wr_hold),
    .start     (start),
    .kind      (kind),
    .lane_we   (lane_we)
  );

  sram_fe_track #(.ADDR_W(ADDR_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind     (kind),
    .step_n   (step_n),
    .addr     (addr),
    .seq_lsb  (seq_lsb),
    .busy     (busy),
    .wr_hold  (wr_hold),
    .seq_base (seq_base),
    .seq_idx  (seq_idx),
    .eff_addr (eff_addr)
  );

  sram_fe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .lane_we  (lane_we),
    .eff_addr (eff_addr),
    .wdata    (wdata),
    .rd_take  (rd_take),
    .ld       (rd_vld),
    .rdata    (rdata)
  );

  sram_fe_outpipe u_outpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_take  (rd_take),
    .wr_now   (wr_now),
    .out_en_n (out_en_n),
    .rd_vld   (rd_vld),
    .rdata_oe (rdata_oe)
  );

  assert_cpu_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !cs_a_n) |-> (kind != ACC_WRITE));

  assert_cpu_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !ctl_stb_n && !cs_a_n && cs_b && !cs_c_n) |=> (busy && !wr_hold));

  assert_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && !wr_all_n) |-> (&lane_we));
endmodule

// File: tb/sync_sram_fe_tb_top.sv
module sync_sram_fe_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        cs_a_n, cs_b, cs_c_n;
  logic        cpu_stb_n, ctl_stb_n, step_n;
  logic        wr_all_n, wr_byte_n;
  logic [3:0]  lane_n;
  logic        out_en_n;
  logic [1:0]  seq_lsb, seq_base, seq_idx;
  logic [31:0] rdata;
  logic        rdata_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // interleaved burst generator living next to the block
  assign seq_lsb = seq_base ^ seq_idx;

  sync_sram_fe #(.ADDR_W(8), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .out_en_n(out_en_n), .seq_lsb(seq_lsb), .seq_base(seq_base),
    .seq_idx(seq_idx), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cpu_stb_n = 1; ctl_stb_n = 1; step_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF;
    cs_a_n = 0; cs_b = 1; cs_c_n = 0; out_en_n = 0;
    addr = '0; wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic desel_flush();
    idle(); ctl_stb_n = 0; cs_b = 0;
    tick(); idle(); tick(); tick();
  endtask

  task automatic wr_ctl(input logic [7:0] a, input logic [31:0] d,
                        input logic all_n, input logic byte_n, input logic [3:0] ln);
    idle(); ctl_stb_n = 0; addr = a; wdata = d;
    wr_all_n = all_n; wr_byte_n = byte_n; lane_n = ln;
    step_n = 0;
    tick(); idle();
  endtask

  // processor-strobe read; junk write inputs in the start cycle when asked
  task automatic rd_word(input logic [7:0] a, input logic junk,
                         output logic [31:0] d, output logic f0, output logic f1);
    idle(); cpu_stb_n = 0; addr = a;
    if (junk) begin wr_all_n = 0; wdata = 32'h0BAD0BAD; end
    tick();
    idle(); #1; f0 = rdata_oe;
    tick();
    idle(); #1; f1 = rdata_oe; d = rdata;
    desel_flush();
  endtask

  task automatic t_reset();
    idle(); rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R12", "oe in reset", {31'd0, rdata_oe}, 32'd0);
    chk("R12", "idx in reset", {30'd0, seq_idx}, 32'd0);
    rst_n = 1;
    tick();
    chk("R12", "oe after reset", {31'd0, rdata_oe}, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] d; logic f0, f1;
    wr_ctl(8'h10, 32'hCAFE0001, 1'b0, 1'b1, 4'hF);
    rd_word(8'h10, 1'b1, d, f0, f1);
    chk("R7", "first cycle off", {31'd0, f0}, 32'd0);
    chk("R6", "oe on data cycle", {31'd0, f1}, 32'd1);
    chk("R4", "same-cycle ctl write", d, 32'hCAFE0001);
    chk("R3", "start-cycle write ignored", d, 32'hCAFE0001);
  endtask

  task automatic t_lanes();
    logic [31:0] d; logic f0, f1;
    wr_ctl(8'h20, 32'h11223344, 1'b0, 1'b1, 4'hF);
    wr_ctl(8'h20, 32'hAABBCCDD, 1'b1, 1'b0, 4'b1010);
    wr_ctl(8'h20, 32'hFFFFFFFF, 1'b1, 1'b1, 4'b0000);
    wr_ctl(8'h20, 32'h99000000, 1'b1, 1'b0, 4'b0111);
    rd_word(8'h20, 1'b0, d, f0, f1);
    chk("R5", "lane mix", d, 32'h99BB33DD);
    wr_ctl(8'h24, 32'h01020304, 1'b0, 1'b0, 4'hF);
    rd_word(8'h24, 1'b0, d, f0, f1);
    chk("R5", "global override", d, 32'h01020304);
  endtask

  task automatic t_cpu_write();
    logic [31:0] d; logic f0, f1;
    wr_ctl(8'h30, 32'h0, 1'b0, 1'b1, 4'hF);
    idle(); cpu_stb_n = 0; addr = 8'h30; wr_all_n = 0; wdata = 32'h77777777;
    tick();
    idle(); wr_all_n = 0; wdata = 32'h12345678; #1;
    chk("R9", "oe off during write", {31'd0, rdata_oe}, 32'd0);
    tick();
    idle(); #1;
    chk("R9", "oe off after write", {31'd0, rdata_oe}, 32'd0);
    tick(); #1;
    chk("R9", "oe stays off", {31'd0, rdata_oe}, 32'd0);
    desel_flush();
    rd_word(8'h30, 1'b0, d, f0, f1);
    chk("R3", "second-cycle write", d, 32'h12345678);
    wr_ctl(8'h34, 32'hA5A5A5A5, 1'b0, 1'b1, 4'hF);
    idle(); cpu_stb_n = 0; addr = 8'h34; wr_all_n = 0; wdata = 32'h0;
    tick();
    desel_flush();
    rd_word(8'h34, 1'b0, d, f0, f1);
    chk("R3", "cpu start no write", d, 32'hA5A5A5A5);
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++)
      wr_ctl(8'h40 + 8'(i), 32'h0B000040 + 32'(i), 1'b0, 1'b1, 4'hF);
    idle(); cpu_stb_n = 0; addr = 8'h41;
    tick();
    for (int j = 1; j <= 6; j++) begin
      int m;
      logic [1:0] ix;
      idle(); step_n = (j <= 3) ? 1'b0 : 1'b1; #1;
      if (j >= 2) begin
        m  = j - 2;
        ix = (m > 3) ? 2'd3 : 2'(m);
        chk("R11", "burst beat", rdata, 32'h0B000040 + 32'(2'b01 ^ ix));
        chk("R11", "burst oe", {31'd0, rdata_oe}, 32'd1);
      end
      tick();
    end
    desel_flush();
  endtask

  task automatic t_dcd();
    idle(); cpu_stb_n = 0; addr = 8'h10;
    tick();
    idle(); ctl_stb_n = 0; cs_c_n = 1; #1;
    chk("R7", "first cycle off", {31'd0, rdata_oe}, 32'd0);
    tick();
    idle(); #1;
    chk("R8", "driven after deselect", {31'd0, rdata_oe}, 32'd1);
    chk("R8", "data after deselect", rdata, 32'hCAFE0001);
    tick(); #1;
    chk("R8", "released next edge", {31'd0, rdata_oe}, 32'd0);
    tick();
  endtask

  task automatic t_select();
    logic [31:0] d; logic f0, f1;
    wr_ctl(8'h50, 32'h50505050, 1'b0, 1'b1, 4'hF);
    for (int v = 0; v < 3; v++) begin
      idle(); ctl_stb_n = 0; wr_all_n = 0; addr = 8'h50;
      wdata = 32'hBAD00000 + 32'(v);
      if (v == 0) cs_a_n = 1;
      if (v == 1) cs_b = 0;
      if (v == 2) cs_c_n = 1;
      tick(); idle(); #1;
      chk("R1", "no drive when deselected", {31'd0, rdata_oe}, 32'd0);
      tick();
    end
    rd_word(8'h50, 1'b0, d, f0, f1);
    chk("R1", "deselected writes dropped", d, 32'h50505050);
  endtask

  task automatic t_priority();
    wr_ctl(8'h60, 32'h60606060, 1'b0, 1'b1, 4'hF);
    idle(); cpu_stb_n = 0; ctl_stb_n = 0; addr = 8'h60;
    wr_all_n = 0; wdata = 32'hDEADBEEF;
    tick();
    idle(); cpu_stb_n = 0; cs_a_n = 1; addr = 8'h70;
    tick();
    idle(); #1;
    chk("R2", "processor wins, read", rdata, 32'h60606060);
    tick(); #1;
    chk("R2", "ignored strobe keeps burst", {31'd0, rdata_oe}, 32'd1);
    chk("R2", "ignored strobe data", rdata, 32'h60606060);
    desel_flush();
  endtask

  task automatic t_oe();
    logic [31:0] d; logic f0, f1;
    idle(); cpu_stb_n = 0; addr = 8'h10;
    tick();
    idle(); tick();
    idle(); #1;
    chk("R10", "oe on", {31'd0, rdata_oe}, 32'd1);
    out_en_n = 1; #1;
    chk("R10", "async off", {31'd0, rdata_oe}, 32'd0);
    out_en_n = 0; #1;
    chk("R10", "async back on", {31'd0, rdata_oe}, 32'd1);
    wr_all_n = 0; wdata = 32'hCAFE0001; #1;
    chk("R9", "write forces off", {31'd0, rdata_oe}, 32'd0);
    tick();
    idle(); #1;
    chk("R9", "off after burst write", {31'd0, rdata_oe}, 32'd0);
    tick(); #1;
    chk("R9", "no continue read after write", {31'd0, rdata_oe}, 32'd0);
    desel_flush();
    rd_word(8'h10, 1'b0, d, f0, f1);
    chk("R9", "new strobe read drives", {31'd0, f1}, 32'd1);
    chk("R6", "read value", d, 32'hCAFE0001);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lanes();
    t_cpu_write();
    t_burst();
    t_dcd();
    t_select();
    t_priority();
    t_oe();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule